// File: doc/BRIEF.md
# Multi-Bank Sorted Packet Distributor

This block is an N-input, N-output packet fabric for one time slot at a time. Up to K packets in the same slot can go to the same outlet. Each input carries a valid bit, a destination address and a payload. There is no field other than the address for steering.

The packets first pass through a bitonic sorting network. It puts the valid packets in ascending address order on its outlets and pushes the empty ones to the end. The sorted outlets are then dealt across K self-routing banyan banks. Sorter outlet j goes to bank j mod K at inlet floor(j/K), and bank inlets that receive no sorter outlet carry an empty packet. Each bank therefore receives a compact, ascending sequence with distinct addresses, which it routes without internal conflict.

Outlet d of bank k drives lane k of output group d, so every group offers K lanes per slot. The result is registered, so it appears one clock after the inputs are sampled. If more than K packets in one slot share an address, the slot cannot be delivered in full, and an overload flag is raised together with that slot's result.

Top module: `kmb_fabric`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `out_vld` and the `overload` flag are zero after that edge.
- R2: A valid packet on input j, with address `in_addr[j*AW +: AW]` and payload `in_pay[j*PW +: PW]`, appears with the same payload on one lane of group d one clock later. Lane k of group d sits at index d*K+k of `out_vld` and at `out_pay[(d*K+k)*PW +: PW]`.
- R3: When exactly K packets share an address in one slot, all K are delivered, one on each of the K lanes of that group.
- R4: Let c ≤ K be the number of valid packets addressed to d, and let s be the number of valid packets with a lower address. Then the valid lanes of group d are exactly (s+t) mod K for t = 0..c-1.
- R5: The address and payload of an input whose valid bit is low have no effect, and a slot with no valid input produces no valid lane.
- R6: `overload` is high one clock after a slot in which more than K valid packets share an address, and low otherwise. When it is high, fewer lanes are valid than packets were offered.
- R7: In a slot without overload, the number of valid lanes equals the number of valid inputs.
- R8: With N=8 and K=3, the addresses (3,0,4,3,4,6,empty,3) give banks 0, 1 and 2 the sequences (0,3,6), (3,4) and (3,4). Group 3 then fills lanes 1, 2 and 0, group 4 fills lanes 1 and 2, and groups 0 and 6 fill lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | N | Valid bit per input |
| in_addr | input | N*AW | Destination address per input, AW = log2 N |
| in_pay | input | N*PW | Payload per input |
| out_vld | output | N*K | Valid bit per lane, index d*K+k |
| out_pay | output | N*K*PW | Payload per lane |
| overload | output | 1 | More than K packets shared an address in the previous slot |

## Verification
The assertions assume that the inputs are known at every sampling edge and that `rst_n` is asserted from the first edge. The conservation property relies on the sorter output being compact and monotone in every bank, which holds only when no address is requested more than K times. For that reason it is guarded by the overload flag rather than by a check of the inputs. Outside the slots where an overload is intended, the stimulus draws addresses with a per-address count capped at K. The overload slots force exactly K+1 requests to one address, so that the flag and the loss property are the only claims made about them.

// File: rtl/kmb_pkg.sv
package kmb_pkg;
    // Perfect-shuffle position: rotate a BITS-wide index left by one.
    function automatic int rotl(input int idx, input int bits);
        return ((idx << 1) | (idx >> (bits - 1))) & ((1 << bits) - 1);
    endfunction

    // Element layout helper: the element width for a given address and payload width.
    function automatic int elem_w(input int aw, input int pw);
        return 1 + aw + pw;
    endfunction
endpackage

// File: rtl/kmb_sorter.sv
// Bitonic sorting network over N elements, fully combinational.
// Each element is {empty, addr, payload}; the sort key is {empty, addr}, so valid
// packets end up in ascending address order and empty ones end up last.
// Assumes N is a power of two.
module kmb_sorter #(
    parameter int N  = 8,
    parameter int AW = 3,
    parameter int PW = 8
) (
    input  logic [kmb_pkg::elem_w(AW, PW)-1:0] din  [N],
    output logic [kmb_pkg::elem_w(AW, PW)-1:0] dout [N]
);
    localparam int EW = kmb_pkg::elem_w(AW, PW);
    localparam int KW = 1 + AW;
    localparam int NS = AW * (AW + 1) / 2;

    logic [EW-1:0] stg [NS+1][N];

    // Stage 0 is the input; the last stage is the result.
    for (genvar i = 0; i < N; i++) begin : g_io
        assign stg[0][i] = din[i];
        assign dout[i]   = stg[NS][i];
    end

    // Merge blocks of size 2^gk, each made of gk compare-exchange steps.
    for (genvar gk = 1; gk <= AW; gk++) begin : g_blk
        for (genvar gt = 0; gt < gk; gt++) begin : g_step
            localparam int S = (gk - 1) * gk / 2 + gt;
            localparam int D = 1 << (gk - 1 - gt);
            localparam int B = 1 << gk;
            for (genvar i = 0; i < N; i++) begin : g_pair
                if ((i & D) == 0) begin : g_cx
                    localparam int P = i + D;
                    logic swap;
                    // The direction of the exchange follows which half of the block i sits in.
                    if ((i & B) == 0) begin : g_up
                        assign swap = stg[S][i][EW-1 -: KW] > stg[S][P][EW-1 -: KW];
                    end else begin : g_dn
                        assign swap = stg[S][i][EW-1 -: KW] < stg[S][P][EW-1 -: KW];
                    end
                    assign stg[S+1][i] = swap ? stg[S][P] : stg[S][i];
                    assign stg[S+1][P] = swap ? stg[S][i] : stg[S][P];
                end
            end
        end
    end
endmodule

// File: rtl/kmb_omega.sv
// Self-routing shuffle-exchange banyan of N inlets, combinational.
// Stage s shuffles the lines, and each 2x2 element then steers by address bit
// AW-1-s. A packet leaves on the outlet equal to its address.
// Assumes a compact ascending input sequence with distinct addresses, which is
// conflict-free. On a conflict the upper input keeps the port and the other is dropped.
module kmb_omega #(
    parameter int N  = 8,
    parameter int AW = 3,
    parameter int PW = 8
) (
    input  logic [kmb_pkg::elem_w(AW, PW)-1:0] din  [N],
    output logic [kmb_pkg::elem_w(AW, PW)-1:0] dout [N]
);
    localparam int EW = kmb_pkg::elem_w(AW, PW);
    localparam logic [EW-1:0] EMPTY = {1'b1, {(EW-1){1'b0}}};

    logic [EW-1:0] lvl [AW+1][N];
    logic [EW-1:0] shf [AW][N];

    // Connect the inlets and the outlets.
    for (genvar i = 0; i < N; i++) begin : g_io
        assign lvl[0][i] = din[i];
        assign dout[i]   = lvl[AW][i];
    end

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int BI = PW + AW - 1 - s;
        // Perfect shuffle ahead of each switching column.
        for (genvar i = 0; i < N; i++) begin : g_shuf
            localparam int R = kmb_pkg::rotl(i, AW);
            assign shf[s][R] = lvl[s][i];
        end
        // 2x2 elements: output b takes the input whose steering bit equals b.
        for (genvar p = 0; p < N / 2; p++) begin : g_sw
            logic [EW-1:0] a, b;
            assign a = shf[s][2*p];
            assign b = shf[s][2*p+1];
            assign lvl[s+1][2*p]   = (!a[EW-1] && !a[BI]) ? a :
                                     (!b[EW-1] && !b[BI]) ? b : EMPTY;
            assign lvl[s+1][2*p+1] = (!a[EW-1] &&  a[BI]) ? a :
                                     (!b[EW-1] &&  b[BI]) ? b : EMPTY;
        end
    end
endmodule

// File: rtl/kmb_fabric.sv
// Top of the distributor: sorter, interleaved deal onto K banyan banks, and an
// output register of N groups with K lanes each. The result is registered one
// clock after the inputs are sampled.
// Assumes N is a power of two and K >= 1. More than K packets on one address is
// flagged as overload; which packets are lost in that slot is not specified.
module kmb_fabric #(
    parameter int N  = 8,
    parameter int K  = 3,
    parameter int PW = 8,
    localparam int AW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      in_vld,
    input  logic [N*AW-1:0]   in_addr,
    input  logic [N*PW-1:0]   in_pay,
    output logic [N*K-1:0]    out_vld,
    output logic [N*K*PW-1:0] out_pay,
    output logic              overload
);
    localparam int EW = kmb_pkg::elem_w(AW, PW);
    localparam int LANES = N * K;
    localparam logic [EW-1:0] EMPTY = {1'b1, {(EW-1){1'b0}}};

    logic [EW-1:0]       pk [N];
    logic [EW-1:0]       so [N];
    logic [N-1:0]        dup;
    logic [LANES-1:0]    nxt_vld;
    logic [LANES*PW-1:0] nxt_pay;

    // Pack each input into the {empty, addr, payload} element.
    for (genvar j = 0; j < N; j++) begin : g_pack
        assign pk[j] = {~in_vld[j], in_addr[j*AW +: AW], in_pay[j*PW +: PW]};
    end

    kmb_sorter #(.N(N), .AW(AW), .PW(PW)) u_sort (.din(pk), .dout(so));

    // Overload: sorted positions j and j+K that are both valid with the same
    // address mean that K+1 packets share that address.
    for (genvar j = 0; j < N; j++) begin : g_dup
        if (j + K < N) begin : g_cmp
            assign dup[j] = !so[j][EW-1] && !so[j+K][EW-1] &&
                            (so[j][PW +: AW] == so[j+K][PW +: AW]);
        end else begin : g_none
            assign dup[j] = 1'b0;
        end
    end

    for (genvar k = 0; k < K; k++) begin : g_bank
        logic [EW-1:0] bin  [N];
        logic [EW-1:0] bout [N];
        // Deal: sorter outlet r*K+k feeds inlet r of bank k; the rest are empty.
        for (genvar r = 0; r < N; r++) begin : g_deal
            if (r * K + k < N) begin : g_used
                assign bin[r] = so[r*K+k];
            end else begin : g_idle
                assign bin[r] = EMPTY;
            end
        end
        kmb_omega #(.N(N), .AW(AW), .PW(PW)) u_bank (.din(bin), .dout(bout));
        // Bank outlet d becomes lane k of group d; a wrong address is never presented.
        for (genvar d = 0; d < N; d++) begin : g_lane
            assign nxt_vld[d*K+k]           = !bout[d][EW-1] && (bout[d][PW +: AW] == AW'(d));
            assign nxt_pay[(d*K+k)*PW +: PW] = bout[d][PW-1:0];
        end
    end

    // Slot register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= '0;
            out_pay  <= '0;
            overload <= 1'b0;
        end else begin
            out_vld  <= nxt_vld;
            out_pay  <= nxt_pay;
            overload <= |dup;
        end
    end
endmodule

// File: rtl/kmb_fabric_chk.sv
// Port-level properties of kmb_fabric, attached with bind.
// Assumes the inputs are known at each sampling edge.
module kmb_fabric_chk #(
    parameter int N = 8,
    parameter int K = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] in_vld,
    input logic [N*K-1:0] out_vld,
    input logic         overload
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_vld == '0 && !overload));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) == '0) |-> (out_vld == '0 && !overload));

    // R7
    conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !overload) |-> ($countones(out_vld) == $past($countones(in_vld))));

    // R6
    overload_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && overload) |-> ($countones(out_vld) < $past($countones(in_vld))));

    // R6
    overload_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && overload) |-> ($past($countones(in_vld)) > K));
endmodule

bind kmb_fabric kmb_fabric_chk #(.N(N), .K(K)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld), .overload(overload)
);

// File: tb/sim_kmb_fabric.sv
`timescale 1ns/1ps
module sim_kmb_fabric;
    localparam int N  = 8;
    localparam int K  = 3;
    localparam int PW = 8;
    localparam int AW = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      in_vld = '0;
    logic [N*AW-1:0]   in_addr = '0;
    logic [N*PW-1:0]   in_pay = '0;
    logic [N*K-1:0]    out_vld;
    logic [N*K*PW-1:0] out_pay;
    logic              overload;

    kmb_fabric #(.N(N), .K(K), .PW(PW)) u0 (.*);

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Stimulus staging and the reference expectation for the next slot.
    bit st_v [N];
    int st_a [N];
    int st_p [N];
    bit have_exp = 0;
    string e_tag;
    logic [N*K-1:0] e_vld;
    bit e_ov;
    int e_cnt;
    longint e_sum [N];
    longint e_sq  [N];

    task automatic chk(input string req, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    // Compare the registered outputs with the expectation of the previous slot.
    task automatic check_prev();
        if (!have_exp) return;
        chk("R6", overload, e_ov);
        if (e_ov) begin
            chk("R6", ($countones(out_vld) < e_cnt), 1);
        end else begin
            chk("R7", $countones(out_vld), e_cnt);
            for (int d = 0; d < N; d++) begin
                longint s1 = 0, s2 = 0;
                chk("R4", out_vld[d*K +: K], e_vld[d*K +: K]);
                for (int k = 0; k < K; k++) begin
                    if (out_vld[d*K+k]) begin
                        longint pv = out_pay[(d*K+k)*PW +: PW];
                        s1 += pv;
                        s2 += pv * pv;
                    end
                end
                chk(e_tag, s1, e_sum[d]);
                chk(e_tag, s2, e_sq[d]);
            end
        end
    endtask

    // Present one slot at a falling edge and derive its expected result.
    task automatic apply(input string tag);
        @(negedge clk);
        check_prev();
        for (int j = 0; j < N; j++) begin
            in_vld[j] = st_v[j];
            in_addr[j*AW +: AW] = AW'(st_a[j]);
            in_pay[j*PW +: PW] = PW'(st_p[j]);
        end
        e_tag = tag;
        e_ov = 0;
        e_vld = '0;
        e_cnt = 0;
        for (int d = 0; d < N; d++) begin
            int c = 0, s = 0;
            e_sum[d] = 0;
            e_sq[d] = 0;
            for (int j = 0; j < N; j++) begin
                if (st_v[j] && st_a[j] == d) begin
                    c++;
                    e_sum[d] += st_p[j];
                    e_sq[d] += longint'(st_p[j]) * st_p[j];
                end
                if (st_v[j] && st_a[j] < d) s++;
            end
            e_cnt += c;
            if (c > K) e_ov = 1;
            else for (int t = 0; t < c; t++) e_vld[d*K + (s + t) % K] = 1'b1;
        end
        have_exp = 1;
    endtask

    // Fill the staging arrays with a random slot, at most CAP packets per address.
    task automatic gen_capped(input int cap, input int skip_addr);
        int cnt [N];
        for (int d = 0; d < N; d++) cnt[d] = 0;
        for (int j = 0; j < N; j++) begin
            int a;
            st_p[j] = $urandom % 256;
            st_v[j] = ($urandom % 4) != 0;
            a = $urandom % N;
            if (st_v[j]) begin
                while (cnt[a] >= cap || a == skip_addr) a = (a + 1) % N;
                cnt[a]++;
            end
            st_a[j] = a;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R1: drive valid traffic while reset is held.
        in_vld = '1;
        in_pay = '1;
        repeat (3) @(negedge clk);
        chk("R1", out_vld, 0);
        chk("R1", overload, 0);
        rst_n = 1'b1;

        // R8: the worked example for N=8, K=3.
        begin
            int ex [N] = '{3, 0, 4, 3, 4, 6, 0, 3};
            for (int j = 0; j < N; j++) begin
                st_a[j] = ex[j];
                st_v[j] = (j != 6);
                st_p[j] = 10 + j;
            end
            apply("R8");
        end

        // R2: full permutations.
        for (int n = 0; n < 10; n++) begin
            for (int j = 0; j < N; j++) begin
                st_a[j] = j;
                st_v[j] = 1;
                st_p[j] = $urandom % 256;
            end
            for (int j = N - 1; j > 0; j--) begin
                int r = $urandom % (j + 1);
                int tmp = st_a[j];
                st_a[j] = st_a[r];
                st_a[r] = tmp;
            end
            apply("R2");
        end

        // R5: invalid inputs with arbitrary address and payload.
        for (int n = 0; n < 3; n++) begin
            for (int j = 0; j < N; j++) begin
                st_v[j] = 0;
                st_a[j] = $urandom % N;
                st_p[j] = $urandom % 256;
            end
            apply("R5");
        end

        // R3: exactly K packets on two addresses, two more on a third.
        for (int n = 0; n < 4; n++) begin
            int tgt [N] = '{5, 2, 5, 7, 2, 5, 2, 7};
            for (int j = 0; j < N; j++) begin
                st_a[j] = tgt[(j + n) % N];
                st_v[j] = 1;
                st_p[j] = $urandom % 256;
            end
            apply("R3");
        end

        // R4 and R2: random slots with per-address counts capped at K.
        for (int n = 0; n < 300; n++) begin
            gen_capped(K, -1);
            apply("R4");
        end

        // R6: K+1 requests to one address, the rest capped.
        for (int n = 0; n < 20; n++) begin
            int x = $urandom % N;
            gen_capped(K, x);
            for (int j = 0; j <= K; j++) begin
                int pos = (j + n) % N;
                st_v[pos] = 1;
                st_a[pos] = x;
            end
            apply("R6");
        end

        // Flush the last expectation with an empty slot.
        for (int j = 0; j < N; j++) st_v[j] = 0;
        apply("R5");
        apply("R5");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule